// File: doc/BRIEF.md
# CCD Vertical Sequence Timing Generator

This block produces the six vertical clock levels that a CCD needs while one horizontal line is read out. A table of pattern groups is presented on ports. Each group is a short list of 6-bit output words, with one word per pixel clock, and has its own length. The active sequence's register set picks one group and the pixel at which that group starts. It also sets how many extra repetitions follow, with one count for odd lines and another for even lines. Up to two freeze/resume windows can either blank the outputs or stall the pattern.

A pulse on `run_start` begins the first line of a field. After that, lines follow one another with no gap. At every line start the block captures the sequence register set and the line length. When `final_line` is high, it takes the separate length meant for the last line of a field. One cycle after each pixel, the block presents the vertical levels for that pixel, together with a line-end strobe and a sequence-done strobe. There is no streaming data path, so all pins are plain control and status.

Top module: `vseq_gen`

## Requirements
- R1: After reset, and until the first `run_start`, `vclk`, `line_end` and `seq_done` are all 0. Every output is registered and shows the state of pixel p in the cycle after the pixel counter held p.
- R2: A `run_start` pulse sets the pixel counter to 0. A line covers pixels 0 to L, where L is the captured 13-bit line length value. `line_end` is high for exactly one cycle, aligned with pixel L.
- R3: The selected group starts at the pixel equal to `cfg_start`. Group g step s is taken from `pat_table` bits [(g*STEPS+s)*6 +: 6], with bit 0 driving V1. Group g has `pat_len_m1[g*3 +: 3]`+1 steps. One step is emitted per pixel. Outside the pattern, `vclk` is 0.
- R4: The pattern runs rep+1 times in a row, so a count of 0 means a single pass. The first line after `run_start` is odd and uses `cfg_rep_odd`. Parity toggles at every line end, and even lines use `cfg_rep_even`.
- R5: `seq_done` pulses for one cycle, aligned with the final step of the final repetition. It does not pulse again in that line.
- R6: A select value of 10 or more plays group 0.
- R7: Bit 0 of `cfg_win_mode` enables window 1 (`cfg_frz1` ≤ pixel < `cfg_res1`), and bit 1 enables window 2. With `cfg_hold` = 0, outputs inside an enabled window are 0 while the pattern position keeps advancing.
- R8: With `cfg_hold` = 1, the pattern stops inside an enabled window. `vclk` keeps its last value and the pattern resumes at the next step once the window ends.
- R9: When `final_line` is high at line start, the line length is taken from `cfg_last_len` instead of `cfg_line_len`.
- R10: Configuration inputs are captured only at line start. A change in the middle of a line has no effect until the next line.
- R11: When a line ends, the next line starts at once. The pattern state is cleared at that point, even if the pattern was still running when the line ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Begins the first line of a field (odd parity) |
| final_line | input | 1 | Selects the last-line length at the next line start |
| cfg_sel | input | 4 | Pattern group select |
| cfg_start | input | 12 | Pattern start pixel |
| cfg_rep_odd | input | 12 | Extra repetitions on odd lines |
| cfg_rep_even | input | 12 | Extra repetitions on even lines |
| cfg_line_len | input | 13 | Last pixel index of a normal line |
| cfg_last_len | input | 13 | Last pixel index of the field's final line |
| cfg_win_mode | input | 2 | Window enables (bit 0 window 1, bit 1 window 2) |
| cfg_hold | input | 1 | 1 = windows stall the pattern, 0 = windows blank it |
| cfg_frz1 | input | 13 | Window 1 first pixel |
| cfg_res1 | input | 13 | Window 1 end pixel (exclusive) |
| cfg_frz2 | input | 13 | Window 2 first pixel |
| cfg_res2 | input | 13 | Window 2 end pixel (exclusive) |
| pat_table | input | 480 | Pattern words, NUM_GRP*STEPS entries of 6 bits |
| pat_len_m1 | input | 30 | Per-group step count minus one, 3 bits each |
| vclk | output | 6 | Vertical clock levels V1..V6 |
| line_end | output | 1 | One-cycle strobe at the last pixel of a line |
| seq_done | output | 1 | One-cycle strobe at the final pattern step |

## Verification
The line wrap and the pattern's own progress can fall in the same cycle. This happens when a pattern is still running as the line's last pixel passes. The bench provokes it with a start position close to the end of a short line, so the pattern cannot finish. It then expects no `seq_done`, and expects the next line to replay the pattern from step 0 at the same start pixel. A second coincidence arises when a blanking window overlaps the final step of the last repetition. There the bench expects `seq_done` to fire while `vclk` stays 0.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int PIX_W  = 13;
  localparam int POS_W  = 12;
  localparam int REP_W  = 12;
  localparam int SEL_W  = 4;
  localparam int VOUT_W = 6;
  localparam int NWIN   = 2;

  typedef struct packed {
    logic [SEL_W-1:0]           grp;
    logic [POS_W-1:0]           start;
    logic [REP_W-1:0]           rep;
    logic [PIX_W-1:0]           len;
    logic [NWIN-1:0]            win_en;
    logic                       hold;
    logic [NWIN-1:0][PIX_W-1:0] frz;
    logic [NWIN-1:0][PIX_W-1:0] res;
  } line_cfg_t;
endpackage

// File: rtl/vseq_line_ctr.sv
module vseq_line_ctr
  import vseq_pkg::*;
#(
  parameter int NUM_GRP = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_start,
  input  logic                 final_line,
  input  line_cfg_t            cfg_base,
  input  logic [REP_W-1:0]     rep_odd,
  input  logic [REP_W-1:0]     rep_even,
  input  logic [PIX_W-1:0]     line_len,
  input  logic [PIX_W-1:0]     last_len,
  output logic                 running,
  output logic [PIX_W-1:0]     pix,
  output line_cfg_t            cfg_q,
  output logic                 new_line,
  output logic                 line_end
);
  logic      odd_q;
  logic      wrap;
  logic      next_odd;
  line_cfg_t nxt;

  always_comb begin
    wrap     = running && (pix == cfg_q.len);
    new_line = run_start || wrap;
    next_odd = run_start ? 1'b1 : ~odd_q;
    nxt      = cfg_base;
    nxt.rep  = next_odd ? rep_odd : rep_even;
    nxt.len  = final_line ? last_len : line_len;
    nxt.grp  = (int'(cfg_base.grp) < NUM_GRP) ? cfg_base.grp : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      pix      <= '0;
      odd_q    <= 1'b0;
      cfg_q    <= '0;
      line_end <= 1'b0;
    end else begin
      line_end <= wrap;
      if (new_line) begin
        running <= 1'b1;
        pix     <= '0;
        odd_q   <= next_odd;
        cfg_q   <= nxt;
      end else if (running) begin
        pix <= pix + 1'b1;
      end
    end
  end

  assert_wrap_to_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !run_start) |=> (running && pix == '0))
    else $error("line did not restart at pixel 0");

  assert_parity_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !run_start) |=> (odd_q != $past(odd_q)))
    else $error("line parity did not toggle");

  assert_first_line_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> odd_q)
    else $error("first line not odd");

  assert_group_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (int'(cfg_q.grp) < NUM_GRP))
    else $error("illegal group latched");

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !new_line) |=> $stable(cfg_q))
    else $error("configuration changed mid-line");
endmodule

// File: rtl/vseq_window.sv
module vseq_window
  import vseq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PIX_W-1:0]           pix,
  input  logic [NWIN-1:0]            win_en,
  input  logic [NWIN-1:0][PIX_W-1:0] frz,
  input  logic [NWIN-1:0][PIX_W-1:0] res,
  output logic                       in_win
);
  logic [NWIN-1:0] hit;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign hit[i] = win_en[i] && (pix >= frz[i]) && (pix < res[i]);
  end

  assign in_win = |hit;

  assert_win_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_en == '0) |-> !in_win)
    else $error("window active while disabled");
endmodule

// File: rtl/vseq_pattern.sv
module vseq_pattern
  import vseq_pkg::*;
#(
  parameter int NUM_GRP = 10,
  parameter int STEPS   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              running,
  input  logic                              new_line,
  input  logic [PIX_W-1:0]                  pix,
  input  logic [SEL_W-1:0]                  grp,
  input  logic [POS_W-1:0]                  start,
  input  logic [REP_W-1:0]                  rep,
  input  logic                              hold,
  input  logic                              in_win,
  input  logic [NUM_GRP*STEPS*VOUT_W-1:0]   pat_table,
  input  logic [NUM_GRP*$clog2(STEPS)-1:0]  pat_len_m1,
  output logic [VOUT_W-1:0]                 vclk,
  output logic                              seq_done
);
  localparam int STEP_W = $clog2(STEPS);

  logic [STEP_W-1:0] step_q;
  logic [REP_W-1:0]  rep_q;
  logic              done_q;
  logic [STEP_W-1:0] grp_len;
  logic [VOUT_W-1:0] cur;
  logic              active, stall, blank, adv, last_step;

  always_comb begin
    grp_len   = pat_len_m1[int'(grp)*STEP_W +: STEP_W];
    cur       = pat_table[(int'(grp)*STEPS + int'(step_q))*VOUT_W +: VOUT_W];
    active    = running && !done_q && ({1'b0, start} <= pix);
    stall     = active && in_win && hold;
    blank     = active && in_win && !hold;
    adv       = active && !stall;
    last_step = (step_q == grp_len) && (rep_q == rep);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= '0;
      rep_q    <= '0;
      done_q   <= 1'b0;
      vclk     <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= adv && last_step;
      if (!active)   vclk <= '0;
      else if (adv)  vclk <= blank ? '0 : cur;
      if (new_line) begin
        step_q <= '0;
        rep_q  <= '0;
        done_q <= 1'b0;
      end else if (adv) begin
        if (step_q == grp_len) begin
          step_q <= '0;
          if (rep_q == rep) done_q <= 1'b1;
          else              rep_q  <= rep_q + 1'b1;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assert_idle_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (vclk == '0))
    else $error("outputs active while idle");

  assert_before_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (pix < {1'b0, start})) |=> (vclk == '0))
    else $error("output before start pixel");

  assert_single_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !new_line) |=> !seq_done)
    else $error("second done pulse in line");

  assert_mask_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (vclk == '0))
    else $error("masked output not idle");

  assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(vclk))
    else $error("held output changed");
endmodule

// File: rtl/vseq_gen.sv
module vseq_gen
  import vseq_pkg::*;
#(
  parameter int NUM_GRP = 10,
  parameter int STEPS   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              run_start,
  input  logic                              final_line,
  input  logic [3:0]                        cfg_sel,
  input  logic [11:0]                       cfg_start,
  input  logic [11:0]                       cfg_rep_odd,
  input  logic [11:0]                       cfg_rep_even,
  input  logic [12:0]                       cfg_line_len,
  input  logic [12:0]                       cfg_last_len,
  input  logic [1:0]                        cfg_win_mode,
  input  logic                              cfg_hold,
  input  logic [12:0]                       cfg_frz1,
  input  logic [12:0]                       cfg_res1,
  input  logic [12:0]                       cfg_frz2,
  input  logic [12:0]                       cfg_res2,
  input  logic [NUM_GRP*STEPS*6-1:0]        pat_table,
  input  logic [NUM_GRP*$clog2(STEPS)-1:0]  pat_len_m1,
  output logic [5:0]                        vclk,
  output logic                              line_end,
  output logic                              seq_done
);
  line_cfg_t        base, cfg_q;
  logic             running, new_line, in_win;
  logic [PIX_W-1:0] pix;

  always_comb begin
    base        = '0;
    base.grp    = cfg_sel;
    base.start  = cfg_start;
    base.win_en = cfg_win_mode;
    base.hold   = cfg_hold;
    base.frz[0] = cfg_frz1;
    base.res[0] = cfg_res1;
    base.frz[1] = cfg_frz2;
    base.res[1] = cfg_res2;
  end

  vseq_line_ctr #(.NUM_GRP(NUM_GRP)) u_ctr (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .final_line(final_line),
    .cfg_base(base), .rep_odd(cfg_rep_odd), .rep_even(cfg_rep_even),
    .line_len(cfg_line_len), .last_len(cfg_last_len),
    .running(running), .pix(pix), .cfg_q(cfg_q), .new_line(new_line),
    .line_end(line_end)
  );

  vseq_window u_win (
    .clk(clk), .rst_n(rst_n), .pix(pix), .win_en(cfg_q.win_en),
    .frz(cfg_q.frz), .res(cfg_q.res), .in_win(in_win)
  );

  vseq_pattern #(.NUM_GRP(NUM_GRP), .STEPS(STEPS)) u_pat (
    .clk(clk), .rst_n(rst_n), .running(running), .new_line(new_line),
    .pix(pix), .grp(cfg_q.grp), .start(cfg_q.start), .rep(cfg_q.rep),
    .hold(cfg_q.hold), .in_win(in_win), .pat_table(pat_table),
    .pat_len_m1(pat_len_m1), .vclk(vclk), .seq_done(seq_done)
  );
endmodule

// File: tb/test_vseq_gen.sv
`timescale 1ns/1ps
module test_vseq_gen;
  localparam int NG = 10;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_start = 1'b0, final_line = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [11:0] cfg_start = '0, cfg_rep_odd = '0, cfg_rep_even = '0;
  logic [12:0] cfg_line_len = '0, cfg_last_len = '0;
  logic [1:0]  cfg_win_mode = '0;
  logic        cfg_hold = 1'b0;
  logic [12:0] cfg_frz1 = '0, cfg_res1 = '0, cfg_frz2 = '0, cfg_res2 = '0;
  logic [NG*NS*6-1:0] pat_table;
  logic [NG*3-1:0]    pat_len_m1;
  logic [5:0] vclk;
  logic       line_end, seq_done;

  int checks = 0;
  int errors = 0;
  int wf1 = 0, wr1 = 0, wf2 = 0, wr2 = 0;

  always #2 clk = ~clk;

  vseq_gen i_vseq_gen (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .final_line(final_line),
    .cfg_sel(cfg_sel), .cfg_start(cfg_start), .cfg_rep_odd(cfg_rep_odd),
    .cfg_rep_even(cfg_rep_even), .cfg_line_len(cfg_line_len),
    .cfg_last_len(cfg_last_len), .cfg_win_mode(cfg_win_mode), .cfg_hold(cfg_hold),
    .cfg_frz1(cfg_frz1), .cfg_res1(cfg_res1), .cfg_frz2(cfg_frz2), .cfg_res2(cfg_res2),
    .pat_table(pat_table), .pat_len_m1(pat_len_m1),
    .vclk(vclk), .line_end(line_end), .seq_done(seq_done)
  );

  function automatic logic [5:0] tv(int g, int s);
    return 6'(((g * 8 + s) % 63) + 1);
  endfunction

  function automatic int glen(int g);
    return (g % 4) + 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_win(int f1, int r1, int f2, int r2);
    wf1 = f1; wr1 = r1; wf2 = f2; wr2 = r2;
    cfg_frz1 = 13'(f1); cfg_res1 = 13'(r1); cfg_frz2 = 13'(f2); cfg_res2 = 13'(r2);
  endtask

  task automatic start_line();
    @(negedge clk) run_start = 1'b1;
    @(negedge clk) run_start = 1'b0;
  endtask

  // Expected outputs for one whole line, derived from R2..R8.
  task automatic check_line(string tag, int g, int st, int rep, int len, int mode,
                            bit hold, int chg_at, int chg_sel, int chg_start);
    int s = 0;
    int rc = 0;
    bit dn = 1'b0;
    bit sd, inw;
    logic [5:0] last = '0;
    logic [5:0] ev;
    for (int p = 0; p <= len; p++) begin
      ev = '0;
      sd = 1'b0;
      inw = (((mode & 1) != 0) && p >= wf1 && p < wr1) ||
            (((mode & 2) != 0) && p >= wf2 && p < wr2);
      if (!dn && p >= st) begin
        if (inw && hold) ev = last;
        else begin
          ev = inw ? 6'd0 : tv(g, s);
          if (s == glen(g) - 1) begin
            s = 0;
            if (rc == rep) begin dn = 1'b1; sd = 1'b1; end
            else rc++;
          end else s++;
        end
      end
      last = ev;
      @(negedge clk);
      chk(tag, "vclk", int'(vclk), int'(ev));
      chk(tag, "seq_done", int'(seq_done), int'(sd));
      chk(tag, "line_end", int'(line_end), int'(p == len));
      if (p == chg_at) begin
        cfg_sel = 4'(chg_sel);
        cfg_start = 12'(chg_start);
      end
    end
  endtask

  task automatic t_reset();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1", "vclk", int'(vclk), 0);
      chk("R1", "line_end", int'(line_end), 0);
      chk("R1", "seq_done", int'(seq_done), 0);
    end
  endtask

  task automatic t_basic();
    set_win(0, 0, 0, 0); cfg_win_mode = 2'd0; cfg_hold = 1'b0;
    cfg_sel = 4'd3; cfg_start = 12'd5; cfg_rep_odd = 12'd1; cfg_rep_even = 12'd1;
    cfg_line_len = 13'd19;
    start_line();
    check_line("R2 R3 R5 basic", 3, 5, 1, 19, 0, 1'b0, -1, 0, 0);
  endtask

  task automatic t_parity();
    cfg_sel = 4'd1; cfg_start = 12'd2; cfg_rep_odd = 12'd0; cfg_rep_even = 12'd2;
    cfg_line_len = 13'd15;
    start_line();
    check_line("R4 odd rep0", 1, 2, 0, 15, 0, 1'b0, -1, 0, 0);
    check_line("R4 R11 even", 1, 2, 2, 15, 0, 1'b0, -1, 0, 0);
    check_line("R4 odd again", 1, 2, 0, 15, 0, 1'b0, -1, 0, 0);
  endtask

  task automatic t_select();
    cfg_sel = 4'd12; cfg_start = 12'd1; cfg_rep_odd = 12'd2; cfg_rep_even = 12'd2;
    cfg_line_len = 13'd7;
    start_line();
    check_line("R6 sel12", 0, 1, 2, 7, 0, 1'b0, -1, 0, 0);
  endtask

  task automatic t_mask();
    set_win(4, 7, 9, 10); cfg_hold = 1'b0;
    cfg_sel = 4'd2; cfg_start = 12'd0; cfg_rep_odd = 12'd3; cfg_rep_even = 12'd3;
    cfg_line_len = 13'd15;
    for (int m = 1; m <= 3; m++) begin
      cfg_win_mode = 2'(m);
      start_line();
      check_line("R7 mask", 2, 0, 3, 15, m, 1'b0, -1, 0, 0);
    end
    // Window 2 covers the final step: done strobe with blanked output.
    set_win(0, 0, 11, 13); cfg_win_mode = 2'd2;
    start_line();
    check_line("R7 R5 mask at done", 2, 0, 3, 15, 2, 1'b0, -1, 0, 0);
  endtask

  task automatic t_hold();
    set_win(2, 5, 12, 14); cfg_win_mode = 2'd1; cfg_hold = 1'b1;
    cfg_sel = 4'd2; cfg_start = 12'd0; cfg_rep_odd = 12'd1; cfg_rep_even = 12'd1;
    cfg_line_len = 13'd15;
    start_line();
    check_line("R8 hold w1", 2, 0, 1, 15, 1, 1'b1, -1, 0, 0);
    cfg_win_mode = 2'd3; set_win(2, 5, 6, 8);
    start_line();
    check_line("R8 hold both", 2, 0, 1, 15, 3, 1'b1, -1, 0, 0);
    cfg_hold = 1'b0; cfg_win_mode = 2'd0;
  endtask

  task automatic t_lastline();
    cfg_sel = 4'd0; cfg_start = 12'd0; cfg_rep_odd = 12'd0; cfg_rep_even = 12'd0;
    cfg_line_len = 13'd19; cfg_last_len = 13'd9; final_line = 1'b1;
    start_line();
    final_line = 1'b0;
    check_line("R9 last len", 0, 0, 0, 9, 0, 1'b0, -1, 0, 0);
    check_line("R9 normal len", 0, 0, 0, 19, 0, 1'b0, -1, 0, 0);
  endtask

  task automatic t_midline();
    cfg_sel = 4'd3; cfg_start = 12'd5; cfg_rep_odd = 12'd1; cfg_rep_even = 12'd1;
    cfg_line_len = 13'd19;
    start_line();
    check_line("R10 unchanged", 3, 5, 1, 19, 0, 1'b0, 7, 5, 2);
    check_line("R10 next line", 5, 2, 1, 19, 0, 1'b0, -1, 0, 0);
  endtask

  task automatic t_wrapcut();
    cfg_sel = 4'd3; cfg_start = 12'd7; cfg_rep_odd = 12'd0; cfg_rep_even = 12'd0;
    cfg_line_len = 13'd9;
    start_line();
    check_line("R11 cut line", 3, 7, 0, 9, 0, 1'b0, -1, 0, 0);
    check_line("R11 R3 restart", 3, 7, 0, 9, 0, 1'b0, -1, 0, 0);
  endtask

  initial begin
    for (int g = 0; g < NG; g++) begin
      pat_len_m1[g*3 +: 3] = 3'(g % 4);
      for (int s = 0; s < NS; s++) pat_table[(g*NS + s)*6 +: 6] = tv(g, s);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_parity();
    t_select();
    t_mask();
    t_hold();
    t_lastline();
    t_midline();
    t_wrapcut();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule